// File: doc/BRIEF.md
# Power-Fail Protected SRAM Access Gate

This block connects an asynchronous SRAM-style host bus to an on-chip byte store and to the eight-byte register window of a timekeeping clock. The bus has active-low chip enable, output enable and write enable, an address and a data byte. The block samples these pins on its own clock and classifies each cycle as a read, a write or idle. It steers the topmost locations to the clock register window and every other location to plain storage. The block does not drive a tristate pad itself. It produces a read byte and a drive-enable flag, and the pad logic places the data bus in high impedance whenever that flag is low.

Two protections sit on top of the decoding. While the power-fail indication is high, the block ignores every bus pin. It commits no write, and it keeps the drive-enable low. A write that is under way when power fails is dropped. After power-fail clears, bus cycles stay ignored until chip enable has been seen high once. A battery-low sample is captured while reset is held. If that sample is set, the first completed write after reset is silently discarded. The flag then clears and later writes behave normally.

Top module: `pfgate_top`

## Requirements
- R1: A read cycle is chip enable low, output enable low and write enable high, while the gate is armed and power-fail is low. After the second rising clock edge following that input change, bus_drive_en is 1 and bus_rdata carries the byte stored at the address.
- R2: bus_drive_en is 0 whenever chip enable or output enable was high at the sampling edge. bus_rdata reads 0 while bus_drive_en is 0.
- R3: Write enable low forces bus_drive_en to 0 even while chip enable and output enable are both low.
- R4: A write window lasts while chip enable and write enable are both low. The write commits when the first of the two rises. It writes exactly one location, using the address and data sampled on the last clock of the window.
- R5: While power-fail is high, the block commits no write, produces no clock-register write strobe and keeps bus_drive_en at 0. This holds even for a read that is already being driven.
- R6: A write window that is open when power-fail rises is abandoned, and the addressed location keeps its previous content.
- R7: After power-fail falls, reads and writes stay ignored until chip enable has been sampled high at least once.
- R8: If batt_low is 1 while reset is asserted, the first write that completes after reset changes nothing. The next write completes normally.
- R9: If batt_low is 0 during reset, the first write after reset is stored normally.
- R10: Addresses 2040 to 2047 (the top MIRROR_N addresses) map to the clock window. A write there gives a one-cycle mirror_wr_en pulse with mirror_wr_idx equal to the low three address bits and with the written data, and it leaves plain storage unchanged. A read there returns byte idx of mirror_rdata, which is bits idx*8+7 down to idx*8. Address 2039 is still plain storage.
- R11: During and directly after reset, bus_drive_en and mirror_wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data from host |
| pwr_fail | input | 1 | Supply out of tolerance |
| batt_low | input | 1 | Battery-low sample, captured during reset |
| mirror_rdata | input | 64 | Eight clock register bytes, byte i at bits 8i+7:8i |
| bus_rdata | output | 8 | Read data toward the pad |
| bus_drive_en | output | 1 | Pad drive enable; low means high impedance |
| mirror_wr_en | output | 1 | One-cycle clock register write strobe |
| mirror_wr_idx | output | 3 | Clock register index for the strobe |
| mirror_wr_data | output | 8 | Clock register write byte |

## Verification
The assertions treat the bus pins and power-fail as levels sampled once per clock, with a fixed two-edge path to the outputs. They assume the host holds each bus phase for at least two clocks and keeps address and data steady across a write window. The stimulus changes every input only on falling clock edges and holds each phase for two or three clocks. It never moves the address inside an open write window, so each pin change is seen cleanly at one sampling edge.

// File: rtl/pfgate_pkg.sv
package pfgate_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Decode of the sampled control pins; write enable wins over output enable.
  function automatic cyc_e classify(input logic ce_n, input logic oe_n, input logic we_n);
    if (ce_n)  return CYC_IDLE;
    if (!we_n) return CYC_WRITE;
    if (!oe_n) return CYC_READ;
    return CYC_IDLE;
  endfunction

endpackage

// File: rtl/pfgate_sampler.sv
module pfgate_sampler
  import pfgate_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pf,
  output cyc_e              s_kind,
  output logic              s_ce_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  output logic              s_pf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_kind  <= CYC_IDLE;
      s_ce_n  <= 1'b1;
      s_addr  <= '0;
      s_wdata <= '0;
      s_pf    <= 1'b0;
    end else begin
      s_kind  <= classify(ce_n, oe_n, we_n);
      s_ce_n  <= ce_n;
      s_addr  <= addr;
      s_wdata <= wdata;
      s_pf    <= pf;
    end
  end

endmodule

// File: rtl/pfgate_access.sv
module pfgate_access
  import pfgate_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              s_kind,
  input  logic              s_ce_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_pf,
  input  logic              batt_low,
  output logic              rd_ok,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);

  logic armed_q;   // bus accepted; cleared by power-fail, set by chip enable high
  logic in_wr_q;   // a write window was open on the previous clock
  logic block_q;   // the next completed write is to be dropped
  logic wr_active;
  logic wr_end;

  assign wr_active = armed_q && !s_pf && (s_kind == CYC_WRITE);
  assign rd_ok     = armed_q && !s_pf && (s_kind == CYC_READ);
  assign wr_end    = in_wr_q && !wr_active && !s_pf;
  assign commit    = wr_end && !block_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      in_wr_q <= 1'b0;
      block_q <= batt_low;
      c_addr  <= '0;
      c_data  <= '0;
    end else begin
      if (s_pf)        armed_q <= 1'b0;
      else if (s_ce_n) armed_q <= 1'b1;
      in_wr_q <= wr_active;
      if (wr_active) begin
        c_addr <= s_addr;
        c_data <= s_wdata;
      end
      if (wr_end) block_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pfgate_store.sv
module pfgate_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pfgate_top.sv
module pfgate_top
  import pfgate_pkg::*;
#(
  parameter  int ADDR_W    = 11,
  parameter  int DATA_W    = 8,
  parameter  int MIRROR_N  = 8,
  localparam int MIR_IDX_W = $clog2(MIRROR_N)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_ce_n,
  input  logic                       bus_oe_n,
  input  logic                       bus_we_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       pwr_fail,
  input  logic                       batt_low,
  input  logic [MIRROR_N*DATA_W-1:0] mirror_rdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_drive_en,
  output logic                       mirror_wr_en,
  output logic [MIR_IDX_W-1:0]       mirror_wr_idx,
  output logic [DATA_W-1:0]          mirror_wr_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MIR_BASE = ADDR_W'(DEPTH - MIRROR_N);

  cyc_e              s_kind;
  logic              s_ce_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic              s_pf;

  pfgate_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst(rst), .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .addr(bus_addr), .wdata(bus_wdata), .pf(pwr_fail),
    .s_kind(s_kind), .s_ce_n(s_ce_n), .s_addr(s_addr), .s_wdata(s_wdata), .s_pf(s_pf)
  );

  logic              rd_ok;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;

  pfgate_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .s_kind(s_kind), .s_ce_n(s_ce_n), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_pf(s_pf), .batt_low(batt_low),
    .rd_ok(rd_ok), .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  logic c_hit;
  logic s_hit;
  assign c_hit = (c_addr >= MIR_BASE);
  assign s_hit = (s_addr >= MIR_BASE);

  logic [DATA_W-1:0] mir_bytes [MIRROR_N];
  for (genvar g = 0; g < MIRROR_N; g++) begin : g_unpack
    assign mir_bytes[g] = mirror_rdata[g*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] ram_q;

  pfgate_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(commit && !c_hit), .waddr(c_addr), .wdata(c_data),
    .raddr(s_addr), .rdata(ram_q)
  );

  logic              drive_q;
  logic              hi_q;
  logic [DATA_W-1:0] mir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q        <= 1'b0;
      hi_q           <= 1'b0;
      mir_q          <= '0;
      mirror_wr_en   <= 1'b0;
      mirror_wr_idx  <= '0;
      mirror_wr_data <= '0;
    end else begin
      drive_q        <= rd_ok;
      hi_q           <= s_hit;
      mir_q          <= mir_bytes[s_addr[MIR_IDX_W-1:0]];
      mirror_wr_en   <= commit && c_hit;
      mirror_wr_idx  <= c_addr[MIR_IDX_W-1:0];
      mirror_wr_data <= c_data;
    end
  end

  assign bus_drive_en = drive_q;
  assign bus_rdata    = drive_q ? (hi_q ? mir_q : ram_q) : '0;

endmodule

// File: rtl/pfgate_checker.sv
module pfgate_checker (
  input logic clk,
  input logic rst,
  input logic pwr_fail,
  input logic bus_ce_n,
  input logic bus_oe_n,
  input logic bus_we_n,
  input logic bus_drive_en,
  input logic mirror_wr_en
);

  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_ce_n || bus_oe_n, 2) |-> !bus_drive_en);

  p_we_mutes_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_we_n, 2) |-> !bus_drive_en);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    mirror_wr_en |=> !mirror_wr_en);

  p_pf_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_fail, 2) |-> !bus_drive_en);

  p_pf_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    mirror_wr_en |-> !$past(pwr_fail, 2));

  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> (!bus_drive_en && !mirror_wr_en));

endmodule

bind pfgate_top pfgate_checker u_chk (
  .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .bus_ce_n(bus_ce_n),
  .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_drive_en(bus_drive_en),
  .mirror_wr_en(mirror_wr_en)
);

// File: tb/pfgate_top_test.sv
module pfgate_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        pf = 1'b0, blow = 1'b0;
  logic [63:0] mrd;
  logic [7:0]  rdata;
  logic        drive, mwe;
  logic [2:0]  midx;
  logic [7:0]  mdata;

  always #4 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_mrd
    assign mrd[i*8 +: 8] = 8'hA0 + 8'(i);
  end

  pfgate_top uut (
    .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wdata), .pwr_fail(pf), .batt_low(blow),
    .mirror_rdata(mrd), .bus_rdata(rdata), .bus_drive_en(drive),
    .mirror_wr_en(mwe), .mirror_wr_idx(midx), .mirror_wr_data(mdata)
  );

  int total = 0, failed = 0;
  bit done = 0;

  logic [7:0]  rq_v[$];
  string       rq_t[$];
  logic [10:0] mq_v[$];
  string       mq_t[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items as the design produces reads and strobes.
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (drive && !prev) begin
          if (rq_v.size() == 0) check(0, "R2 unexpected drive", 1, 0);
          else begin
            automatic logic [7:0] e = rq_v.pop_front();
            automatic string t = rq_t.pop_front();
            check(rdata === e, t, rdata, e);
          end
        end
        if (mwe) begin
          if (mq_v.size() == 0) check(0, "R5 unexpected strobe", {midx, mdata}, 0);
          else begin
            automatic logic [10:0] e = mq_v.pop_front();
            automatic string t = mq_t.pop_front();
            check({midx, mdata} === e, t, {midx, mdata}, e);
          end
        end
      end
      prev = drive;
    end
  end

  task automatic do_reset(input logic b);
    @(negedge clk);
    rst = 1'b1; blow = b; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit strobe, input string t);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    if (strobe) begin mq_v.push_back({a[2:0], d}); mq_t.push_back(t); end
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    rq_v.push_back(e); rq_t.push_back(t);
    repeat (3) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R11 reset state
    @(negedge clk);
    check(drive == 0, "R11 drive in reset", drive, 0);
    check(mwe == 0, "R11 strobe in reset", mwe, 0);
    do_reset(1'b0);
    check(drive == 0 && rdata == 0, "R11 drive after reset", drive, 0);

    // R9, R4, R10 writes
    wr(11'd10, 8'h11, 0, "");
    wr(11'd20, 8'h22, 0, "");
    wr(11'd2039, 8'h39, 0, "");
    wr(11'd2040, 8'h5A, 1, "R10 strobe idx0");
    wr(11'd2047, 8'hC3, 1, "R10 strobe idx7");
    rd(11'd10, 8'h11, "R9 first write stored");
    rd(11'd20, 8'h22, "R1 read plain");
    rd(11'd2039, 8'h39, "R10 last plain address");
    rd(11'd2040, 8'hA0, "R10 mirror read idx0");
    rd(11'd2047, 8'hA7, "R10 mirror read idx7");
    rd(11'd10, 8'h11, "R4 single location");

    // R2 deselect
    @(negedge clk); addr = 11'd10; ce_n = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    check(drive == 0 && rdata == 0, "R2 oe high", drive, 0);
    ce_n = 1'b1; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    check(drive == 0, "R2 ce high", drive, 0);
    oe_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 write enable mutes outputs; also a write
    @(negedge clk); addr = 11'd30; wdata = 8'h30; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    check(drive == 0, "R3 we low with oe low", drive, 0);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(11'd30, 8'h30, "R4 write ended by first rise");

    // R5 writes and strobes ignored under power-fail
    @(negedge clk); pf = 1'b1;
    repeat (2) @(negedge clk);
    wr(11'd20, 8'hEE, 0, "");
    wr(11'd2041, 8'h12, 0, "");
    @(negedge clk); addr = 11'd10; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    check(drive == 0, "R5 read under power-fail", drive, 0);
    ce_n = 1'b1; oe_n = 1'b1; pf = 1'b0;
    repeat (3) @(negedge clk);
    rd(11'd20, 8'h22, "R5 write suppressed");

    // R5 power-fail cuts a read already driven; R7 stays ignored after release
    @(negedge clk); addr = 11'd10; ce_n = 1'b0; oe_n = 1'b0;
    rq_v.push_back(8'h11); rq_t.push_back("R1 read before power-fail");
    repeat (3) @(negedge clk);
    pf = 1'b1;
    repeat (2) @(negedge clk);
    check(drive == 0, "R5 drive cut by power-fail", drive, 0);
    pf = 1'b0;
    repeat (4) @(negedge clk);
    check(drive == 0, "R7 read ignored before ce high", drive, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 abandoned write, R7 write ignored after release
    wr(11'd40, 8'h40, 0, "");
    @(negedge clk); addr = 11'd40; wdata = 8'h99; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    pf = 1'b1;
    repeat (3) @(negedge clk);
    pf = 1'b0; wdata = 8'h77;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(11'd40, 8'h40, "R6 R7 location unchanged");
    wr(11'd40, 8'h44, 0, "");
    rd(11'd40, 8'h44, "R7 accepted after ce high");

    // R8 battery-low drops first write only
    do_reset(1'b1);
    wr(11'd10, 8'h55, 0, "");
    rd(11'd10, 8'h11, "R8 first write dropped");
    wr(11'd10, 8'h66, 0, "");
    rd(11'd10, 8'h66, "R8 second write stored");

    repeat (4) @(negedge clk);
    check(rq_v.size() == 0, "R1 reads all seen", rq_v.size(), 0);
    check(mq_v.size() == 0, "R10 strobes all seen", mq_v.size(), 0);
    finish_run();
  end

endmodule